// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block sits between an image sensor or video decoder and the rest of an imaging pipeline. It samples a parallel pixel bus on the pixel clock and recovers frame and line timing. Each sample that belongs to the active picture comes out on a streaming output with a valid strobe, a first-of-frame flag, a first-of-line flag and a format tag. Timing comes either from two level-qualified sync pins or from four-word timing codes carried inside the data stream, as configuration selects.

The bus is `PIX_W` bits wide, from 8 to 16. In the normal mode every clock carries one sample. In the nibble mode only the four low bus lines are used, and two clocks make one byte: the high nibble comes first. The format tag marks the stream as one of three YUV/RGB arrangements or as generic data such as raw Bayer or compressed images. Generic data passes through with no change. The output cannot stall. If the consumer is not ready when a sample leaves, a sticky overflow flag records the lost sample.

In embedded mode every sample takes part in the code search, so the output runs a fixed three-sample window behind the input. The three preamble words of a code can then be withdrawn once the fourth word identifies them as a code.

Top module: `cam_capture_top`

## Requirements
- R1: With `cfg_nibble`=0, one sample is taken on every clock, and every active sample leaves on `out_data` with all `PIX_W` bits unchanged, whatever the format tag (generic data included).
- R2: With `cfg_nibble`=1, a byte is formed from `bus_data[3:0]` of two consecutive clocks, high nibble first. It leaves as `out_data[7:0]` with the upper bits zero, and the upper bus lines are ignored.
- R3: In pin mode with nibble capture, any change of `bus_vsync` or `bus_hsync` level makes that clock's nibble the high nibble of a new byte, so that a stray nibble in blanking does not misalign the following data.
- R4: In pin mode (`cfg_embedded`=0) a sample is active only when `bus_vsync`=1 and `bus_hsync`=1 in its cycle(s). No other sample ever asserts `out_valid`.
- R5: In embedded mode the low 8 bits of four consecutive samples FF, 00, 00, XY form a timing code. XY bit 7 is 1, bit 6 is F, bit 5 is V and bit 4 is H. A valid code with V=0 and H=0 opens a line, and any other valid code closes it. Code words never assert `out_valid`, and only samples inside an open line do.
- R6: The XY protection bits [3:0] must equal {V^H, F^H, F^V, F^V^H} with bit 7 set. Otherwise `code_err` pulses for one clock and the line and frame state is left unchanged.
- R7: `out_sof` marks the first active sample after frame blanking (a sample with `bus_vsync`=0, or a valid code with V=1). `out_sol` marks the first active sample after line blanking (a sample with `bus_hsync`=0, or a valid opening code). Both flags are only ever high together with `out_valid`.
- R8: `out_fmt` carries `cfg_format` with the encoding 0 = YUV 4:4:4, 1 = YUV 4:2:2, 2 = RGB, 3 = generic.
- R9: `overflow` is set when `out_valid` is high while `out_ready` is low, and stays set until reset.
- R10: Synchronous active-high reset clears `out_valid`, `out_sof`, `out_sol`, `code_err` and `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_embedded | input | 1 | 1: timing codes in the data, 0: sync pins |
| cfg_nibble | input | 1 | 1: two 4-bit transfers per byte |
| cfg_format | input | 2 | Format tag applied to the stream |
| bus_data | input | PIX_W | Parallel pixel bus |
| bus_vsync | input | 1 | Frame qualifier pin, high during active frame |
| bus_hsync | input | 1 | Line qualifier pin, high during active line |
| out_ready | input | 1 | Consumer ready (does not stall the block) |
| out_valid | output | 1 | Active sample present |
| out_data | output | PIX_W | Sample value |
| out_sof | output | 1 | First active sample of a frame |
| out_sol | output | 1 | First active sample of a line |
| out_fmt | output | 2 | Format tag |
| code_err | output | 1 | Pulse on a timing code with bad protection bits |
| overflow | output | 1 | Sticky: a sample left while not ready |

## Verification
The bench goes after the code words at the edges of a line. A decoder that did not withdraw the preamble would leak FF/00/00 values into the stream at each line end. A code with corrupted protection bits is placed where an opening code belongs: a design that trusted it would emit the blanking data that follows. A single stray nibble is placed in line blanking. Without the phase realignment on a sync edge, every byte of the next line would come out nibble-swapped. Samples with only one of the two sync pins high are mixed into blanking, and a design that qualified on a single pin would output them.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        FMT_YUV444  = 2'd0,
        FMT_YUV422  = 2'd1,
        FMT_RGB     = 2'd2,
        FMT_GENERIC = 2'd3
    } cap_fmt_e;

    // Number of preamble words ahead of the XY word of a timing code
    localparam int unsigned PRE_LEN  = 3;
    localparam logic [7:0]  PRE_HEAD = 8'hFF;
    localparam logic [7:0]  PRE_ZERO = 8'h00;

    typedef struct packed {
        logic act;
        logic sof;
        logic sol;
    } cap_mark_t;

    function automatic logic [3:0] xy_guard(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic xy_sound(input logic [7:0] xy);
        return xy[7] && (xy[3:0] == xy_guard(xy[6], xy[5], xy[4]));
    endfunction

endpackage

// File: rtl/cap_nibble_asm.sv
module cap_nibble_asm #(
    parameter int unsigned PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nibble_mode,
    input  logic             pin_mode,
    input  logic [PIX_W-1:0] bus_data,
    input  logic             bus_vs,
    input  logic             bus_hs,
    output logic             a_valid,
    output logic [PIX_W-1:0] a_data,
    output logic             a_vs,
    output logic             a_hs
);
    logic       phase_q;
    logic [3:0] hi_q;
    logic       vs_q, hs_q;
    logic       pin_edge;
    logic       eff_phase;
    logic [PIX_W-1:0] nib_word;

    assign pin_edge  = pin_mode && ((bus_vs != vs_q) || (bus_hs != hs_q));
    assign eff_phase = pin_edge ? 1'b0 : phase_q;

    always_comb begin
        nib_word      = '0;
        nib_word[7:0] = {hi_q, bus_data[3:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            hi_q    <= '0;
            vs_q    <= 1'b0;
            hs_q    <= 1'b0;
            a_valid <= 1'b0;
            a_data  <= '0;
            a_vs    <= 1'b0;
            a_hs    <= 1'b0;
        end else begin
            vs_q <= bus_vs;
            hs_q <= bus_hs;
            a_vs <= bus_vs;
            a_hs <= bus_hs;
            if (!nibble_mode) begin
                a_valid <= 1'b1;
                a_data  <= bus_data;
                phase_q <= 1'b0;
            end else if (!eff_phase) begin
                hi_q    <= bus_data[3:0];
                phase_q <= 1'b1;
                a_valid <= 1'b0;
            end else begin
                a_valid <= 1'b1;
                a_data  <= nib_word;
                phase_q <= 1'b0;
            end
        end
    end

    // R1: full-rate capture delivers a sample on every clock
    assert_full_rate_R1: assert property (@(posedge clk) disable iff (rst)
        !nibble_mode |=> a_valid);

    // R2: nibble capture never delivers on two clocks in a row
    assert_half_rate_R2: assert property (@(posedge clk) disable iff (rst)
        (nibble_mode && a_valid) |=> !a_valid);

endmodule

// File: rtl/cap_sync_dec.sv
module cap_sync_dec
    import cap_pkg::*;
#(
    parameter int unsigned PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             embedded,
    input  logic             a_valid,
    input  logic [PIX_W-1:0] a_data,
    input  logic             a_vs,
    input  logic             a_hs,
    output logic             o_valid,
    output logic [PIX_W-1:0] o_data,
    output logic             o_sof,
    output logic             o_sol,
    output logic             code_err
);
    localparam int unsigned LAST = PRE_LEN - 1;

    logic [PIX_W-1:0] win_d [PRE_LEN];
    cap_mark_t        win_m [PRE_LEN];
    logic             line_open_q;
    logic             sof_pend_q, sol_pend_q;
    logic             pre_hit;
    logic             cur_act;
    cap_mark_t        new_mark;
    logic [7:0]       xy;

    assign xy = a_data[7:0];

    // Preamble: oldest window word is the head, younger ones are zero
    always_comb begin
        pre_hit = embedded;
        for (int i = 0; i < PRE_LEN; i++) begin
            if (i == LAST) pre_hit = pre_hit && (win_d[i][7:0] == PRE_HEAD);
            else           pre_hit = pre_hit && (win_d[i][7:0] == PRE_ZERO);
        end
    end

    always_comb begin
        if (embedded) cur_act = line_open_q && !pre_hit;
        else          cur_act = a_vs && a_hs;
        new_mark.act = cur_act;
        new_mark.sof = cur_act && sof_pend_q;
        new_mark.sol = cur_act && sol_pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PRE_LEN; i++) begin
                win_d[i] <= '0;
                win_m[i] <= '0;
            end
            line_open_q <= 1'b0;
            sof_pend_q  <= 1'b0;
            sol_pend_q  <= 1'b0;
            o_valid     <= 1'b0;
            o_data      <= '0;
            o_sof       <= 1'b0;
            o_sol       <= 1'b0;
            code_err    <= 1'b0;
        end else begin
            code_err <= 1'b0;
            if (!a_valid) begin
                o_valid <= 1'b0;
                o_sof   <= 1'b0;
                o_sol   <= 1'b0;
            end else begin
                o_valid <= win_m[LAST].act && !pre_hit;
                o_sof   <= win_m[LAST].sof && !pre_hit;
                o_sol   <= win_m[LAST].sol && !pre_hit;
                o_data  <= win_d[LAST];
                for (int i = LAST; i > 0; i--) begin
                    win_d[i] <= win_d[i-1];
                    win_m[i] <= pre_hit ? '0 : win_m[i-1];
                end
                win_d[0] <= a_data;
                win_m[0] <= new_mark;

                if (cur_act) begin
                    sof_pend_q <= 1'b0;
                    sol_pend_q <= 1'b0;
                end
                if (!embedded) begin
                    if (!a_vs) sof_pend_q <= 1'b1;
                    if (!a_hs) sol_pend_q <= 1'b1;
                end else if (pre_hit) begin
                    if (xy_sound(xy)) begin
                        line_open_q <= !xy[5] && !xy[4];
                        if (xy[5]) sof_pend_q <= 1'b1;
                        if (!xy[5] && !xy[4]) sol_pend_q <= 1'b1;
                    end else begin
                        code_err <= 1'b1;
                    end
                end
            end
        end
    end

    // R7: the markers only ride on a delivered sample
    assert_sof_on_valid_R7: assert property (@(posedge clk) disable iff (rst)
        o_sof |-> o_valid);
    assert_sol_on_valid_R7: assert property (@(posedge clk) disable iff (rst)
        o_sol |-> o_valid);

    // R6: a code error can only follow a clock spent in embedded mode
    assert_err_embedded_R6: assert property (@(posedge clk) disable iff (rst)
        code_err |-> $past(embedded));

    // R5: output only moves on a clock that carried an input sample
    assert_valid_follows_input_R5: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> $past(a_valid));

endmodule

// File: rtl/cam_capture_top.sv
module cam_capture_top
    import cap_pkg::*;
#(
    parameter int unsigned PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_embedded,
    input  logic             cfg_nibble,
    input  logic [1:0]       cfg_format,
    input  logic [PIX_W-1:0] bus_data,
    input  logic             bus_vsync,
    input  logic             bus_hsync,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sof,
    output logic             out_sol,
    output logic [1:0]       out_fmt,
    output logic             code_err,
    output logic             overflow
);
    logic             a_valid;
    logic [PIX_W-1:0] a_data;
    logic             a_vs, a_hs;
    cap_fmt_e         fmt_q;

    cap_nibble_asm #(.PIX_W(PIX_W)) asm_i (
        .clk        (clk),
        .rst        (rst),
        .nibble_mode(cfg_nibble),
        .pin_mode   (!cfg_embedded),
        .bus_data   (bus_data),
        .bus_vs     (bus_vsync),
        .bus_hs     (bus_hsync),
        .a_valid    (a_valid),
        .a_data     (a_data),
        .a_vs       (a_vs),
        .a_hs       (a_hs)
    );

    cap_sync_dec #(.PIX_W(PIX_W)) dec_i (
        .clk     (clk),
        .rst     (rst),
        .embedded(cfg_embedded),
        .a_valid (a_valid),
        .a_data  (a_data),
        .a_vs    (a_vs),
        .a_hs    (a_hs),
        .o_valid (out_valid),
        .o_data  (out_data),
        .o_sof   (out_sof),
        .o_sol   (out_sol),
        .code_err(code_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q    <= FMT_YUV444;
            overflow <= 1'b0;
        end else begin
            fmt_q <= cap_fmt_e'(cfg_format);
            if (out_valid && !out_ready) overflow <= 1'b1;
        end
    end

    assign out_fmt = fmt_q;

    // R9: overflow is sticky and set by an unaccepted sample
    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    assert_overflow_set_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> overflow);

endmodule

// File: tb/cam_capture_top_tb_top.sv
module cam_capture_top_tb_top;
    localparam int unsigned PIX_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_embedded = 1'b0;
    logic             cfg_nibble = 1'b0;
    logic [1:0]       cfg_format = 2'd0;
    logic [PIX_W-1:0] bus_data = '0;
    logic             bus_vsync = 1'b0;
    logic             bus_hsync = 1'b0;
    logic             out_ready = 1'b1;
    logic             out_valid;
    logic [PIX_W-1:0] out_data;
    logic             out_sof, out_sol;
    logic [1:0]       out_fmt;
    logic             code_err;
    logic             overflow;

    always #2.5 clk = ~clk;

    cam_capture_top #(.PIX_W(PIX_W)) dut_i (.*);

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          mon_en = 1'b0;
    bit          done = 1'b0;
    string       tag = "R10";
    int unsigned err_seen = 0;
    int unsigned err_exp = 0;
    logic [PIX_W-1:0] q_data [$];
    logic             q_sof  [$];
    logic             q_sol  [$];
    bit m_sofp, m_solp, m_open;

    task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_xy(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [PIX_W-1:0] safe_word();
        logic [PIX_W-1:0] w;
        w = PIX_W'($urandom);
        w[7:0] = 8'(($urandom % 254) + 1);
        return w;
    endfunction

    function automatic void push_exp(input logic [PIX_W-1:0] d);
        q_data.push_back(d);
        q_sof.push_back(m_sofp);
        q_sol.push_back(m_solp);
        m_sofp = 1'b0;
        m_solp = 1'b0;
    endfunction

    // Output monitor: every delivered sample must match the next expected one
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (code_err) err_seen++;
            if (out_valid) begin
                if (q_data.size() == 0) begin
                    chk(tag, "unexpected valid", 1, 0);
                end else begin
                    chk(tag, "data", out_data, q_data.pop_front());
                    chk("R7", "sof", out_sof, q_sof.pop_front());
                    chk("R7", "sol", out_sol, q_sol.pop_front());
                    chk("R8", "fmt", out_fmt, cfg_format);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // Pin-mode sample, one or two clocks depending on cfg_nibble
    task automatic pin_sample(input logic [PIX_W-1:0] d, input bit vs, input bit hs);
        bus_vsync = vs;
        bus_hsync = hs;
        if (cfg_nibble) begin
            bus_data = PIX_W'($urandom);
            bus_data[3:0] = d[7:4];
            cyc();
            bus_data = PIX_W'($urandom);
            bus_data[3:0] = d[3:0];
            cyc();
        end else begin
            bus_data = d;
            cyc();
        end
        if (vs && hs) push_exp(cfg_nibble ? PIX_W'(d[7:0]) : d);
        else begin
            if (!vs) m_sofp = 1'b1;
            if (!hs) m_solp = 1'b1;
        end
    endtask

    task automatic emb_word(input logic [PIX_W-1:0] d);
        bus_data = d;
        cyc();
    endtask

    task automatic emb_code(input bit f, input bit v, input bit h, input bit bad);
        logic [7:0] xy;
        xy = mk_xy(f, v, h);
        if (bad) xy[0] = ~xy[0];
        emb_word(PIX_W'(8'hFF));
        emb_word(PIX_W'(8'h00));
        emb_word(PIX_W'(8'h00));
        emb_word(PIX_W'(xy));
        if (bad) err_exp++;
        else begin
            if (v) m_sofp = 1'b1;
            m_open = !v && !h;
            if (m_open) m_solp = 1'b1;
        end
    endtask

    task automatic emb_data(input logic [PIX_W-1:0] d);
        emb_word(d);
        if (m_open) push_exp(d);
    endtask

    task automatic do_reset();
        mon_en = 1'b0;
        rst = 1'b1;
        bus_vsync = 1'b0;
        bus_hsync = 1'b0;
        bus_data = '0;
        cyc();
        cyc();
        rst = 1'b0;
        q_data.delete();
        q_sof.delete();
        q_sol.delete();
        m_sofp = 1'b0;
        m_solp = 1'b0;
        m_open = 1'b0;
        err_seen = 0;
        err_exp = 0;
        mon_en = 1'b1;
    endtask

    task automatic pin_flush();
        for (int i = 0; i < 6; i++) pin_sample(PIX_W'($urandom), 1'b0, 1'b0);
        cyc();
        cyc();
        chk(tag, "samples left undelivered", q_data.size(), 0);
    endtask

    // One pin-timed frame; blanking mixes single-pin-high samples (R4)
    task automatic pin_frame(input int lines, input int len, input bit stray);
        pin_sample(PIX_W'($urandom), 1'b0, 1'b1);
        pin_sample(PIX_W'($urandom), 1'b0, 1'b0);
        for (int l = 0; l < lines; l++) begin
            pin_sample(PIX_W'($urandom), 1'b1, 1'b0);
            pin_sample(PIX_W'($urandom), 1'b1, 1'b0);
            if (stray) begin
                // one lone nibble in line blanking (R3)
                bus_data = PIX_W'($urandom);
                cyc();
            end
            for (int p = 0; p < len; p++) pin_sample(PIX_W'($urandom), 1'b1, 1'b1);
        end
        pin_sample(PIX_W'($urandom), 1'b1, 1'b0);
        pin_sample(PIX_W'($urandom), 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();
        rst = 1'b1;
        cyc();
        tag = "R10";
        @(negedge clk);
        chk("R10", "out_valid in reset", out_valid, 0);
        chk("R10", "out_sof in reset", out_sof, 0);
        chk("R10", "out_sol in reset", out_sol, 0);
        chk("R10", "code_err in reset", code_err, 0);
        chk("R10", "overflow in reset", overflow, 0);

        // Pin timing, full rate, YUV 4:2:2
        cfg_format = 2'd1;
        do_reset();
        tag = "R4";
        pin_frame(3, 8, 1'b0);
        pin_frame(2, 5, 1'b0);
        pin_flush();

        // Pin timing, generic data passes untouched
        cfg_format = 2'd3;
        do_reset();
        tag = "R1";
        pin_frame(2, 12, 1'b0);
        pin_flush();

        // Embedded codes, RGB tag, with a corrupted opening code
        cfg_format = 2'd2;
        cfg_embedded = 1'b1;
        do_reset();
        tag = "R5";
        for (int fr = 0; fr < 2; fr++) begin
            emb_code(1'(fr), 1'b1, 1'b1, 1'b0);
            for (int i = 0; i < 3; i++) emb_data(safe_word());
            emb_code(1'(fr), 1'b1, 1'b0, 1'b0);
            for (int i = 0; i < 3; i++) emb_data(safe_word());
            for (int l = 0; l < 3; l++) begin
                emb_code(1'(fr), 1'b0, 1'b0, (fr == 1) && (l == 1));
                for (int p = 0; p < 6 + int'($urandom % 4); p++) emb_data(safe_word());
                emb_code(1'(fr), 1'b0, 1'b1, 1'b0);
                for (int i = 0; i < 4; i++) emb_data(safe_word());
            end
        end
        for (int i = 0; i < 6; i++) emb_data(safe_word());
        cyc();
        cyc();
        chk("R5", "samples left undelivered", q_data.size(), 0);
        chk("R6", "code errors seen", err_seen, err_exp);
        chk("R6", "code errors planted", err_exp, 1);

        // Nibble capture on pins, YUV 4:4:4, stray nibbles in blanking
        cfg_embedded = 1'b0;
        cfg_nibble = 1'b1;
        cfg_format = 2'd0;
        do_reset();
        tag = "R2";
        pin_frame(2, 6, 1'b0);
        tag = "R3";
        pin_frame(3, 5, 1'b1);
        pin_flush();
        chk("R9", "no overflow while ready", overflow, 0);

        // Consumer not ready: overflow sets and holds
        cfg_nibble = 1'b0;
        out_ready = 1'b0;
        tag = "R9";
        pin_frame(1, 4, 1'b0);
        pin_flush();
        out_ready = 1'b1;
        @(negedge clk);
        chk("R9", "overflow after unready sample", overflow, 1);
        for (int i = 0; i < 10; i++) pin_sample(PIX_W'($urandom), 1'b0, 1'b0);
        @(negedge clk);
        chk("R9", "overflow sticky", overflow, 1);
        chk("R9", "checks made", (checks > 12), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule